// File: doc/BRIEF.md
# Qualified Fault Latch

This block screens a fault line that arrives from an isolation path before the fault is allowed to stop a gate-drive transmitter. A fresh rising edge on the synchronized fault line opens a qualification window whose length is set by a register input. If the line stays high for every sample of that window, the fault is accepted. Any low sample inside the window throws the attempt away, and the next attempt starts again from zero.

An accepted fault sets a sticky flag and raises an inhibit output that the drive encoder uses to stop sending drive commands. The flag is cleared only by a rising edge on the clear input. After power-up the clear line must stay low until the flag has first been set. If the fault line is tied low, the flag never sets. An enable input stops the qualification logic without touching the flag.

Top module: `fault_qual_latch`

## Requirements
- R1: `fault_in` and `clear_in` each pass through a two-flop synchronizer. When `fault_in` is first sampled high at clock edge m and the window length is 1, `latch_o` reads 0 after edge m+1 and reads 1 after edge m+2.
- R2: The effective window length W equals `win_len`, or 1 when `win_len` is 0. The fault is accepted when the synchronized line is high for W consecutive samples, counting from the first high sample after a low one. When `fault_in` is first sampled high at edge m and then held high, `latch_o` reads 1 after edge m+W+1 and not before.
- R3: A low sample before the window completes discards the attempt. High samples from earlier attempts never add up to a later one.
- R4: Once set, `latch_o` holds at 1 until it is cleared, whatever the fault line and enable do. `inhibit_o` is 1 exactly when `latch_o` is 1.
- R5: A rising edge on `clear_in`, sampled at edge m, makes `latch_o` read 0 after edge m+2. While `clear_in` stays high it does not clear again. After it falls, it does not block new faults.
- R6: While the latch is set, a fault line that stays high starts no qualification. After a clear, a new attempt needs a fresh low-to-high transition of the fault line.
- R7: If the synchronized clear line is high in the cycle in which a window completes, the latch stays at 0.
- R8: While `enable` is 0, an attempt in progress is abandoned and no attempt starts. The latch keeps its value.
- R9: A fault line held at 0 never sets the latch.
- R10: During and after the synchronous active-high reset `rst`, `latch_o` and `inhibit_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows qualification attempts when 1 |
| fault_in | input | 1 | Asynchronous fault line from the isolation path |
| clear_in | input | 1 | Asynchronous clear line; its rising edge clears the latch |
| win_len | input | WIN_W | Qualification window length in clock samples (0 acts as 1) |
| latch_o | output | 1 | Sticky accepted-fault flag |
| inhibit_o | output | 1 | Stops drive transmission while the fault flag is set |

## Verification
The assertions assume that `win_len` is valid in every cycle and that the clear line obeys the power-up rule, so the latch cannot be set and cleared by the same edge. They also assume that `enable` is sampled directly, without synchronization. The bench meets these assumptions by driving every input on the falling clock edge. The random phase holds the fault line for runs of 1 to 10 cycles against windows of 1 to 8, so runs fall just short of, exactly at, and beyond the window. It applies clear pulses and enable drops sparsely, so the latch spends time both set and clear.

// File: rtl/fql_pkg.sv
package fql_pkg;

    typedef enum logic {
        QS_IDLE = 1'b0,
        QS_RUN  = 1'b1
    } qual_state_e;

    typedef struct packed {
        logic fault;
        logic clear;
    } line_pair_t;

    localparam int LINE_BITS = $bits(line_pair_t);

endpackage

// File: rtl/fql_sync.sv
module fql_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[i] <= '0;
            else     stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/fql_window.sv
module fql_window
    import fql_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             fault_s,
    input  logic             latched,
    input  logic [WIN_W-1:0] win_len,
    output logic             qual
);
    localparam int CW = WIN_W + 1;

    qual_state_e      st, st_nxt;
    logic [WIN_W-1:0] cnt, cnt_nxt;
    logic             fault_q;
    logic             rise;
    logic [CW-1:0]    need, seen;

    assign rise = fault_s & ~fault_q;
    assign need = (win_len == '0) ? CW'(1) : {1'b0, win_len};
    assign seen = {1'b0, cnt} + CW'(1);

    always_comb begin
        qual    = 1'b0;
        st_nxt  = st;
        cnt_nxt = cnt;
        case (st)
            QS_IDLE: begin
                if (enable && rise && !latched) begin
                    if (need <= CW'(1)) begin
                        qual = 1'b1;
                    end else begin
                        st_nxt  = QS_RUN;
                        cnt_nxt = WIN_W'(1);
                    end
                end
            end
            QS_RUN: begin
                if (!enable || !fault_s) begin
                    st_nxt = QS_IDLE;
                end else if (seen >= need) begin
                    qual   = 1'b1;
                    st_nxt = QS_IDLE;
                end else begin
                    cnt_nxt = cnt + WIN_W'(1);
                end
            end
            default: st_nxt = QS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= QS_IDLE;
            cnt     <= '0;
            fault_q <= 1'b0;
        end else begin
            st      <= st_nxt;
            cnt     <= cnt_nxt;
            fault_q <= fault_s;
        end
    end

    p_quiet_when_latched_r6: assert property (@(posedge clk) disable iff (rst)
        latched |-> !qual);
    p_drop_ends_run_r3: assert property (@(posedge clk) disable iff (rst)
        (st == QS_RUN && !fault_s) |=> (st == QS_IDLE));
    p_enable_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !qual);
    p_run_count_r2: assert property (@(posedge clk) disable iff (rst)
        (st == QS_RUN) |-> (cnt != '0));
endmodule

// File: rtl/fql_latch.sv
module fql_latch (
    input  logic clk,
    input  logic rst,
    input  logic clear_s,
    input  logic qual,
    output logic flag
);
    logic clear_q;
    logic clear_rise;

    assign clear_rise = clear_s & ~clear_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            clear_q <= 1'b0;
        end else begin
            clear_q <= clear_s;
            if (clear_rise)            flag <= 1'b0;
            else if (qual && !clear_s) flag <= 1'b1;
        end
    end

    p_set_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(qual));
    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (flag && !clear_rise) |=> flag);
    p_clear_edge_r5: assert property (@(posedge clk) disable iff (rst)
        clear_rise |=> !flag);
    p_clear_priority_r7: assert property (@(posedge clk) disable iff (rst)
        (clear_s && !flag) |=> !flag);
endmodule

// File: rtl/fault_qual_latch.sv
module fault_qual_latch
    import fql_pkg::*;
#(
    parameter int WIN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             fault_in,
    input  logic             clear_in,
    input  logic [WIN_W-1:0] win_len,
    output logic             latch_o,
    output logic             inhibit_o
);
    line_pair_t raw, synced;
    logic       qual;
    logic       flag;

    assign raw.fault = fault_in;
    assign raw.clear = clear_in;

    fql_sync #(.WIDTH(LINE_BITS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(synced)
    );

    fql_window #(.WIN_W(WIN_W)) u_window (
        .clk(clk), .rst(rst), .enable(enable), .fault_s(synced.fault),
        .latched(flag), .win_len(win_len), .qual(qual)
    );

    fql_latch u_latch (
        .clk(clk), .rst(rst), .clear_s(synced.clear), .qual(qual), .flag(flag)
    );

    assign latch_o   = flag;
    assign inhibit_o = flag;

    p_reset_clear_r10: assert property (@(posedge clk) rst |=> !latch_o);
endmodule

// File: tb/fault_qual_latch_test.sv
`timescale 1ns/1ps
module fault_qual_latch_test;
    localparam int WIN_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b1;
    logic             fault_in = 1'b0;
    logic             clear_in = 1'b0;
    logic [WIN_W-1:0] win_len = 8'd1;
    logic             latch_o, inhibit_o;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    fault_qual_latch #(.WIN_W(WIN_W)) uut (
        .clk(clk), .rst(rst), .enable(enable), .fault_in(fault_in),
        .clear_in(clear_in), .win_len(win_len),
        .latch_o(latch_o), .inhibit_o(inhibit_o)
    );

    always #2.5 clk = ~clk;

    // Reference: sample-level model built from the requirements
    bit d1, d2, d3, c1, c2, c3, m_active, m_latch, m_qual;
    int m_cnt;

    function automatic int eff_w(input logic [WIN_W-1:0] w);
        return (w == 0) ? 1 : int'(w);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            d1 = 0; d2 = 0; d3 = 0; c1 = 0; c2 = 0; c3 = 0;
            m_active = 0; m_latch = 0; m_cnt = 0;
        end else begin
            m_qual = 0;
            if (!m_active) begin
                if (enable && d2 && !d3 && !m_latch) begin
                    if (eff_w(win_len) <= 1) m_qual = 1;
                    else begin m_active = 1; m_cnt = 1; end
                end
            end else if (!enable || !d2) begin
                m_active = 0;
            end else if (m_cnt + 1 >= eff_w(win_len)) begin
                m_qual = 1; m_active = 0;
            end else begin
                m_cnt++;
            end
            if (c2 && !c3)           m_latch = 0;
            else if (m_qual && !c2)  m_latch = 1;
            d3 = d2; d2 = d1; d1 = fault_in;
            c3 = c2; c2 = c1; c1 = clear_in;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse_clear();
        clear_in = 1; tick(3); clear_in = 0; tick(2);
    endtask

    initial begin
        int hold = 0;
        void'($urandom(32'h5EED_1234));
        tick(3);
        chk("R10 latch in reset", latch_o, 1'b0);
        rst = 0;
        tick(1);
        chk("R10 latch after reset", latch_o, 1'b0);
        chk("R10 inhibit after reset", inhibit_o, 1'b0);

        // R9: tied-low fault
        tick(20);
        chk("R9 low fault never sets", latch_o, 1'b0);

        // R1/R2: window of one, latency through synchronizer
        win_len = 8'd1; fault_in = 1;
        tick(1); chk("R1 edge m", latch_o, 1'b0);
        tick(1); chk("R1 edge m+1", latch_o, 1'b0);
        tick(1); chk("R1 edge m+2", latch_o, 1'b1);
        chk("R4 inhibit follows latch", inhibit_o, 1'b1);

        // R5: clear edge with fault still high; R6: no restart
        clear_in = 1;
        tick(2); chk("R4 latch held before clear lands", latch_o, 1'b1);
        tick(1); chk("R5 clear at m+2", latch_o, 1'b0);
        chk("R4 inhibit drops", inhibit_o, 1'b0);
        tick(10); chk("R6 steady fault no restart", latch_o, 1'b0);
        clear_in = 0;
        tick(5); chk("R6 still no restart after clear falls", latch_o, 1'b0);

        // R2: window of four
        fault_in = 0; tick(4);
        win_len = 8'd4; fault_in = 1;
        tick(5); chk("R2 W=4 not yet at m+4", latch_o, 1'b0);
        tick(1); chk("R2 W=4 set at m+5", latch_o, 1'b1);
        // R5: clear held high then released does not block
        pulse_clear();
        fault_in = 0; tick(4);
        chk("R5 cleared", latch_o, 1'b0);

        // R3: broken runs do not accumulate
        win_len = 8'd5;
        fault_in = 1; tick(4); fault_in = 0; tick(1);
        fault_in = 1; tick(4); fault_in = 0; tick(4);
        chk("R3 short runs discarded", latch_o, 1'b0);
        fault_in = 1; tick(6); chk("R3 full run not before m+6", latch_o, 1'b0);
        tick(1); chk("R3 full run accepted", latch_o, 1'b1);

        // R7: clear high while window completes
        clear_in = 1; tick(3);
        chk("R7 cleared", latch_o, 1'b0);
        fault_in = 0; tick(4);
        fault_in = 1; tick(10);
        chk("R7 clear high wins", latch_o, 1'b0);
        clear_in = 0; tick(5);
        chk("R6 no fresh rise after clear", latch_o, 1'b0);
        fault_in = 0; tick(4);

        // R8: enable drop abandons attempt, latch retained
        win_len = 8'd6; fault_in = 1; tick(3);
        enable = 0; tick(1); enable = 1;
        tick(12); chk("R8 abandoned attempt", latch_o, 1'b0);
        fault_in = 0; tick(4); fault_in = 1; tick(10);
        chk("R8 attempt after enable", latch_o, 1'b1);
        enable = 0; fault_in = 0; tick(5);
        chk("R8 latch kept while disabled", latch_o, 1'b1);
        enable = 1;
        pulse_clear();

        // Random phase checked against the model
        for (int i = 0; i < 4000; i++) begin
            if (hold == 0) begin
                fault_in = ($urandom_range(0, 1) == 1);
                hold = $urandom_range(1, 10);
            end
            hold--;
            if ($urandom_range(0, 99) < 3) win_len = WIN_W'($urandom_range(0, 8));
            clear_in = ($urandom_range(0, 39) == 0) ? 1'b1 : (clear_in && $urandom_range(0, 2) != 0);
            enable = ($urandom_range(0, 49) != 0);
            tick(1);
            chk("R2 random latch vs model", latch_o, m_latch);
            chk("R4 random inhibit vs model", inhibit_o, m_latch);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errs++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule